// File: doc/BRIEF.md
# Local Interrupt Controller Message Unit

Each processor in a multiprocessor system has one of these units. It is a small register file on a 32-bit register bus. It holds the processor's identifier, a unit enable with a spurious vector, an end-of-interrupt strobe and a 64-bit command register. Software writes the destination into the upper command word. Writing the lower command word then sends an inter-processor message, such as an INIT or a start-up to all other processors.

The message leaves through a valid/accept handshake that carries the vector, delivery mode, destination mode, level, trigger, shorthand and destination. From the moment the lower word is written until the system accepts the message, a busy bit in the lower word reads as set. The unit ignores any new command while a message is outstanding. It refuses commands whose delivery mode is reserved and flags them, and it sends nothing at all while it is disabled.

Top module: `lic_ipi_unit`

## Requirements
- R1: The identifier register at offset 0x020 stores bits 31:24 of a write. It reads back as {id, 24'b0} and resets to zero.
- R2: Any write to offset 0x0B0 raises `eoi_pulse` for exactly the following cycle. A read of 0x0B0 returns zero.
- R3: The register at offset 0x0F0 stores the spurious vector in bits 7:0 and the enable in bit 8 (1 = enabled). It resets to 0x000000FF and bits 31:9 read as zero.
- R4: The upper command word at offset 0x310 stores the destination in bits 31:24 and reads back as {dest, 24'b0}.
- R5: The lower command word at offset 0x300 reads back with these fields: vector in bits 7:0, delivery mode in 10:8, destination mode in 11 (1 = logical), busy status in 12, level in 14, trigger in 15 and shorthand in 19:18. All other bits read as zero, and writes to bit 12 have no effect.
- R6: A write to 0x300 that is accepted, is not a reserved mode and is made while enabled raises `msg_valid` from the next cycle. The message carries the written fields and the destination held at that moment. The mode codes are 000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT and 110 start-up. The shorthand codes are 00 none, 01 self, 10 all including self and 11 all excluding self.
- R7: The busy bit and `msg_valid` stay at 1 until the first cycle in which `msg_accept` is high. Both read 0 from the cycle after that.
- R8: A write to 0x300 while a message is outstanding changes nothing and sends nothing. This holds even in the cycle in which the message is accepted.
- R9: A write to 0x300 with delivery mode 011 or 111 sends nothing, leaves the lower word unchanged and sets `cmd_fault`. The next accepted non-reserved write to 0x300 clears `cmd_fault`.
- R10: While the enable is 0, a valid write to 0x300 updates the lower word but sends no message and leaves the busy bit at 0.
- R11: The message fields stay constant while `msg_valid` is high, even if the upper word is rewritten.
- R12: Offsets other than the five above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt command |
| cmd_fault | output | 1 | Last command used a reserved mode |
| msg_valid | output | 1 | Message outstanding |
| msg_accept | input | 1 | System takes the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_dest_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Level, 1 = assert |
| msg_trigger | output | 1 | Trigger, 1 = level |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | 8 | Destination identifier |

## Verification
Two events can fall in the same cycle: acceptance of the outstanding message, and a fresh write to the lower command word. The bench drives `msg_accept` high in the very cycle it writes a new command. It expects the write to be lost, so the busy bit and `msg_valid` go to 0 while the lower word keeps the earlier command. A second overlap rewrites the upper word while a message waits, and the bench judges the result by the destination that stays on `msg_dest`. The reference model is updated on every edge and compared with every output on every cycle.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int REG_W = 32;
  localparam int ID_W  = 8;

  localparam logic [11:0] OFS_ID     = 12'h020;
  localparam logic [11:0] OFS_EOI    = 12'h0B0;
  localparam logic [11:0] OFS_SPUR   = 12'h0F0;
  localparam logic [11:0] OFS_CMD_LO = 12'h300;
  localparam logic [11:0] OFS_CMD_HI = 12'h310;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV_A  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV_B  = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [1:0] shorthand;
    logic       trigger;
    logic       level;
    logic       dest_logical;
    dmode_e     mode;
    logic [7:0] vector;
  } cmd_lo_t;

  function automatic logic mode_reserved(input logic [2:0] m);
    return m[1:0] == 2'b11;
  endfunction

  function automatic cmd_lo_t unpack_lo(input logic [REG_W-1:0] w);
    cmd_lo_t c;
    c.vector       = w[7:0];
    c.mode         = dmode_e'(w[10:8]);
    c.dest_logical = w[11];
    c.level        = w[14];
    c.trigger      = w[15];
    c.shorthand    = w[19:18];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_lo(input cmd_lo_t c, input logic busy);
    logic [REG_W-1:0] w;
    w        = '0;
    w[7:0]   = c.vector;
    w[10:8]  = c.mode;
    w[11]    = c.dest_logical;
    w[12]    = busy;
    w[14]    = c.level;
    w[15]    = c.trigger;
    w[19:18] = c.shorthand;
    return w;
  endfunction
endpackage

// File: rtl/lic_addr_decode.sv
module lic_addr_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_id,
  output logic              hit_eoi,
  output logic              hit_spur,
  output logic              hit_lo,
  output logic              hit_hi
);
  import lic_pkg::*;

  assign hit_id   = (addr == ADDR_W'(OFS_ID));
  assign hit_eoi  = (addr == ADDR_W'(OFS_EOI));
  assign hit_spur = (addr == ADDR_W'(OFS_SPUR));
  assign hit_lo   = (addr == ADDR_W'(OFS_CMD_LO));
  assign hit_hi   = (addr == ADDR_W'(OFS_CMD_HI));
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_id,
  input  logic                    wr_eoi,
  input  logic                    wr_spur,
  input  logic                    wr_hi,
  input  logic [lic_pkg::ID_W-1:0] top_byte,
  input  logic [8:0]              spur_bits,
  output logic [lic_pkg::ID_W-1:0] local_id,
  output logic [lic_pkg::ID_W-1:0] dest_hi,
  output logic [7:0]              spur_vec,
  output logic                    unit_en,
  output logic                    eoi_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_id  <= '0;
      dest_hi   <= '0;
      spur_vec  <= 8'hFF;
      unit_en   <= 1'b0;
      eoi_pulse <= 1'b0;
    end else begin
      eoi_pulse <= wr_eoi;
      if (wr_id)   local_id <= top_byte;
      if (wr_hi)   dest_hi  <= top_byte;
      if (wr_spur) begin
        spur_vec <= spur_bits[7:0];
        unit_en  <= spur_bits[8];
      end
    end
  end
endmodule

// File: rtl/lic_cmd_launch.sv
module lic_cmd_launch (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_lo,
  input  lic_pkg::cmd_lo_t         lo_in,
  input  logic                     unit_en,
  input  logic [lic_pkg::ID_W-1:0] dest_hi,
  input  logic                     msg_accept,
  output lic_pkg::cmd_lo_t         lo_q,
  output lic_pkg::cmd_lo_t         msg_q,
  output logic [lic_pkg::ID_W-1:0] msg_dest_q,
  output logic                     busy,
  output logic                     fault,
  output logic                     take,
  output logic                     launch
);
  import lic_pkg::*;

  logic open_wr;
  assign open_wr = wr_lo && !busy;
  assign take    = open_wr && !mode_reserved(lo_in.mode);
  assign launch  = take && unit_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      msg_q      <= '0;
      msg_dest_q <= '0;
      busy       <= 1'b0;
      fault      <= 1'b0;
    end else begin
      if (open_wr) fault <= !take;
      if (take) lo_q <= lo_in;
      if (launch) begin
        msg_q      <= lo_in;
        msg_dest_q <= dest_hi;
        busy       <= 1'b1;
      end else if (busy && msg_accept) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lic_ipi_unit.sv
module lic_ipi_unit #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eoi_pulse,
  output logic              cmd_fault,
  output logic              msg_valid,
  input  logic              msg_accept,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_dest_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [1:0]        msg_shorthand,
  output logic [7:0]        msg_dest
);
  import lic_pkg::*;

  localparam int TOP_LSB = REG_W - ID_W;

  logic hit_id, hit_eoi, hit_spur, hit_lo, hit_hi;
  logic [ID_W-1:0] local_id, dest_hi, msg_dest_q;
  logic [7:0] spur_vec;
  logic unit_en, busy, take, launch;
  cmd_lo_t lo_q, msg_q;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[TOP_LSB-1:20], reg_wdata[17:16], reg_wdata[13:12]};

  lic_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .hit_id(hit_id), .hit_eoi(hit_eoi),
    .hit_spur(hit_spur), .hit_lo(hit_lo), .hit_hi(hit_hi)
  );

  lic_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_id(reg_we && hit_id), .wr_eoi(reg_we && hit_eoi),
    .wr_spur(reg_we && hit_spur), .wr_hi(reg_we && hit_hi),
    .top_byte(reg_wdata[REG_W-1:TOP_LSB]), .spur_bits(reg_wdata[8:0]),
    .local_id(local_id), .dest_hi(dest_hi), .spur_vec(spur_vec),
    .unit_en(unit_en), .eoi_pulse(eoi_pulse)
  );

  lic_cmd_launch u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_lo(reg_we && hit_lo),
    .lo_in(unpack_lo(reg_wdata)), .unit_en(unit_en), .dest_hi(dest_hi),
    .msg_accept(msg_accept), .lo_q(lo_q), .msg_q(msg_q),
    .msg_dest_q(msg_dest_q), .busy(busy), .fault(cmd_fault),
    .take(take), .launch(launch)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_id)   reg_rdata = {local_id, {TOP_LSB{1'b0}}};
    if (hit_spur) reg_rdata = {{(REG_W-9){1'b0}}, unit_en, spur_vec};
    if (hit_hi)   reg_rdata = {dest_hi, {TOP_LSB{1'b0}}};
    if (hit_lo)   reg_rdata = pack_lo(lo_q, busy);
  end

  assign msg_valid        = busy;
  assign msg_vector       = msg_q.vector;
  assign msg_mode         = msg_q.mode;
  assign msg_dest_logical = msg_q.dest_logical;
  assign msg_level        = msg_q.level;
  assign msg_trigger      = msg_q.trigger;
  assign msg_shorthand    = msg_q.shorthand;
  assign msg_dest         = msg_dest_q;
endmodule

// File: rtl/lic_ipi_checker.sv
module lic_ipi_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              eoi_pulse,
  input logic              msg_valid,
  input logic              msg_accept,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic [7:0]        msg_dest,
  input logic [1:0]        msg_shorthand,
  input logic              unit_en
);
  import lic_pkg::*;

  a_r7_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_accept |=> msg_valid);

  a_r7_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_accept |=> !msg_valid);

  a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_accept |=> $stable(msg_vector) && $stable(msg_mode)
      && $stable(msg_dest) && $stable(msg_shorthand));

  a_r9_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !(msg_mode == 3'b011 || msg_mode == 3'b111));

  a_r10_send_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(unit_en));

  a_r2_eoi_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(reg_we && reg_addr == ADDR_W'(OFS_EOI)));

  a_r5_status_bit_tracks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(OFS_CMD_LO) |-> reg_rdata[12] == msg_valid);
endmodule

bind lic_ipi_unit lic_ipi_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .eoi_pulse(eoi_pulse), .msg_valid(msg_valid),
  .msg_accept(msg_accept), .msg_vector(msg_vector), .msg_mode(msg_mode),
  .msg_dest(msg_dest), .msg_shorthand(msg_shorthand), .unit_en(unit_en)
);

// File: tb/lic_ipi_unit_test.sv
module lic_ipi_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic msg_accept = 1'b0;
  logic [31:0] reg_rdata;
  logic eoi_pulse, cmd_fault, msg_valid, msg_dest_logical, msg_level, msg_trigger;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;
  logic [1:0] msg_shorthand;

  int n_checks = 0;
  int n_fail = 0;
  bit run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lic_ipi_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eoi_pulse(eoi_pulse),
    .cmd_fault(cmd_fault), .msg_valid(msg_valid), .msg_accept(msg_accept),
    .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_logical(msg_dest_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand), .msg_dest(msg_dest)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_id, m_dst, m_spv, m_lo, m_msg, m_mdst;
  bit m_en, m_pend, m_fault, m_eoi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_id <= 0; m_dst <= 0; m_spv <= 255; m_en <= 0; m_lo <= 0;
      m_msg <= 0; m_mdst <= 0; m_pend <= 0; m_fault <= 0; m_eoi <= 0;
    end else begin
      m_eoi <= reg_we && reg_addr == 12'h0B0;
      if (m_pend && msg_accept) m_pend <= 0;
      if (reg_we) begin
        if (reg_addr == 12'h020) m_id <= int'(reg_wdata >> 24);
        if (reg_addr == 12'h310) m_dst <= int'(reg_wdata >> 24);
        if (reg_addr == 12'h0F0) begin
          m_spv <= int'(reg_wdata & 32'hFF);
          m_en  <= reg_wdata[8];
        end
        if (reg_addr == 12'h300 && !m_pend) begin
          if (((reg_wdata >> 8) & 3) == 3) m_fault <= 1;
          else begin
            m_fault <= 0;
            m_lo <= int'(reg_wdata & 32'h000C_CFFF);
            if (m_en) begin
              m_pend <= 1;
              m_msg  <= int'(reg_wdata & 32'h000C_CFFF);
              m_mdst <= m_dst;
            end
          end
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h020: return 32'(m_id) << 24;
      12'h310: return 32'(m_dst) << 24;
      12'h0F0: return 32'(m_spv) + (m_en ? 32'h100 : 32'h0);
      12'h300: return 32'(m_lo) | (m_pend ? 32'h1000 : 32'h0);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h020: return "R1 id read";
      12'h0B0: return "R2 eoi read";
      12'h0F0: return "R3 spurious read";
      12'h310: return "R4 dest read";
      12'h300: return "R5 low word read";
      default: return "R12 unmapped read";
    endcase
  endfunction

  // Compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    if (run) begin
      #(CLK_PERIOD/4);
      check32(tag_of(reg_addr), reg_rdata, exp_read(reg_addr));
      check32("R2 eoi pulse", 32'(eoi_pulse), 32'(m_eoi));
      check32("R7 msg_valid", 32'(msg_valid), 32'(m_pend));
      check32("R9 fault flag", 32'(cmd_fault), 32'(m_fault));
      if (m_pend) begin
        check32("R6 msg vector", 32'(msg_vector), 32'(m_msg & 255));
        check32("R6 msg mode", 32'(msg_mode), 32'((m_msg >> 8) & 7));
        check32("R6 msg dest mode", 32'(msg_dest_logical), 32'((m_msg >> 11) & 1));
        check32("R6 msg level", 32'(msg_level), 32'((m_msg >> 14) & 1));
        check32("R6 msg trigger", 32'(msg_trigger), 32'((m_msg >> 15) & 1));
        check32("R6 msg shorthand", 32'(msg_shorthand), 32'((m_msg >> 18) & 3));
        check32("R11 msg dest", 32'(msg_dest), 32'(m_mdst));
      end
    end
  end

  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d, input logic acc);
    reg_we = we; reg_addr = a; reg_wdata = d; msg_accept = acc;
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    reg_addr = 12'h020; #1 check32("R1 reset id", reg_rdata, 32'h0);
    reg_addr = 12'h0F0; #1 check32("R3 reset spurious", reg_rdata, 32'h0000_00FF);
    reg_addr = 12'h300; #1 check32("R5 reset low word", reg_rdata, 32'h0);
    check32("R7 reset msg_valid", 32'(msg_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1; run = 1'b1;

    cyc(1, 12'h020, 32'hA5FF_FFFF, 0);
    cyc(0, 12'h020, 0, 0);
    check32("R1 id field only", reg_rdata, 32'hA500_0000);

    cyc(1, 12'h0B0, 32'hDEAD_BEEF, 0);
    check32("R2 eoi raised", 32'(eoi_pulse), 1);
    cyc(0, 12'h0B0, 0, 0);
    check32("R2 eoi single cycle", 32'(eoi_pulse), 0);
    check32("R2 eoi reads zero", reg_rdata, 0);

    // disabled: fields stored, nothing sent (R10)
    cyc(1, 12'h300, 32'h000C_4500, 0);
    check32("R10 no send while disabled", 32'(msg_valid), 0);
    cyc(0, 12'h300, 0, 0);
    check32("R10 low word stored", reg_rdata, 32'h000C_4500);

    cyc(1, 12'h0F0, 32'hFFFF_F1CF, 0);
    cyc(0, 12'h0F0, 0, 0);
    check32("R3 enable and vector", reg_rdata, 32'h0000_01CF);

    cyc(1, 12'h310, 32'h03FF_FFFF, 0);
    cyc(0, 12'h310, 0, 0);
    check32("R4 dest field", reg_rdata, 32'h0300_0000);

    // INIT to all excluding self
    cyc(1, 12'h300, 32'h000C_4500, 0);
    check32("R6 INIT valid", 32'(msg_valid), 1);
    check32("R6 INIT mode", 32'(msg_mode), 5);
    check32("R6 INIT shorthand", 32'(msg_shorthand), 3);
    cyc(0, 12'h300, 0, 0);
    check32("R7 busy bit set", reg_rdata, 32'h000C_5500);
    cyc(1, 12'h310, 32'h0700_0000, 0);
    cyc(1, 12'h300, 32'h000C_4611, 0);
    check32("R11 dest held", 32'(msg_dest), 32'h03);
    check32("R8 write ignored while busy", 32'(msg_vector), 32'h00);
    cyc(0, 12'h300, 0, 1);
    check32("R7 cleared after accept", reg_rdata, 32'h000C_4500);

    // start-up with vector 0x11, then a write in the accept cycle
    cyc(1, 12'h300, 32'h000C_4611, 0);
    check32("R6 startup mode", 32'(msg_mode), 6);
    check32("R6 startup vector", 32'(msg_vector), 32'h11);
    check32("R6 startup dest", 32'(msg_dest), 32'h07);
    cyc(1, 12'h300, 32'h0000_4020, 1);
    check32("R8 same-cycle write dropped", 32'(msg_valid), 0);
    cyc(0, 12'h300, 0, 0);
    check32("R8 low word kept", reg_rdata, 32'h000C_4611);

    // reserved modes
    cyc(1, 12'h300, 32'h0000_0300, 0);
    check32("R9 fault on 011", 32'(cmd_fault), 1);
    check32("R9 nothing sent", 32'(msg_valid), 0);
    cyc(1, 12'h300, 32'h0000_0700, 0);
    check32("R9 fault on 111", 32'(cmd_fault), 1);
    cyc(0, 12'h300, 0, 0);
    check32("R9 low word unchanged", reg_rdata, 32'h000C_4611);
    cyc(1, 12'h300, 32'h0000_8A33, 1);
    check32("R9 fault cleared", 32'(cmd_fault), 0);
    check32("R6 logical dest mode", 32'(msg_dest_logical), 1);
    check32("R6 level trigger", 32'(msg_trigger), 1);
    cyc(0, 12'h300, 0, 1);
    check32("R7 accept drops valid", 32'(msg_valid), 0);

    // disable again
    cyc(1, 12'h0F0, 32'h0000_00FF, 0);
    cyc(1, 12'h300, 32'h000C_4500, 0);
    check32("R10 disabled again", 32'(msg_valid), 0);

    // unmapped offset
    cyc(1, 12'h040, 32'hFFFF_FFFF, 0);
    cyc(0, 12'h040, 0, 0);
    check32("R12 unmapped reads zero", reg_rdata, 0);
    cyc(0, 12'h020, 0, 0);
    check32("R12 id untouched", reg_rdata, 32'hA500_0000);

    repeat (3) cyc(0, 12'h300, 0, 0);
    run = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule